// File: doc/BRIEF.md
# Branch Decision and Next-PC Unit

This block holds the program counter of a single-cycle 32-bit core and chooses its value for the next cycle. In the usual case the counter steps forward by four bytes, one instruction word. When the decoder marks the current instruction as a conditional branch, the block compares the two register operands. The three-bit condition field of the instruction picks the comparison. If the condition is met, the counter is loaded with its own value plus the branch offset instead of stepping forward.

The offset arrives already sign-extended to the full data width. Its lowest bit is treated as zero whatever value it holds, so targets always fall on even byte addresses. The current counter value goes to the rest of the core. A narrower copy of its low bits addresses the instruction memory.

Top module: `br_next_pc`

## Requirements
- R1: A high `rst` at a rising clock edge sets `pc` to 0 on that edge, whatever the other inputs are, including a branch that would be taken.
- R2: When `is_branch` is low, `pc` advances by exactly 4 on each rising edge, wrapping modulo 2^32.
- R3: With `is_branch` high, condition code 000 is taken when `rs1_val` equals `rs2_val`, and code 001 is taken when they differ.
- R4: Code 100 is taken when `rs1_val` is less than `rs2_val` as two's-complement signed values. Code 101 is taken when `rs1_val` is greater than or equal to `rs2_val` as signed values.
- R5: Code 110 is taken when `rs1_val` is less than `rs2_val` as unsigned values. Code 111 is taken when `rs1_val` is greater than or equal to `rs2_val` as unsigned values.
- R6: A taken branch loads `pc` with `pc + imm`, with bit 0 of `imm` forced to 0. The sum is modulo 2^32, so negative offsets move backwards. A branch that is not taken gives `pc + 4`.
- R7: Codes 010 and 011 are never taken; with `is_branch` high they give `pc + 4`.
- R8: `fetch_addr` always equals the low 16 bits of `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| is_branch | input | 1 | Current instruction is a conditional branch |
| funct3 | input | 3 | Branch condition code |
| rs1_val | input | 32 | First compared operand |
| rs2_val | input | 32 | Second compared operand |
| imm | input | 32 | Sign-extended branch offset in bytes |
| pc | output | 32 | Current program counter |
| fetch_addr | output | 16 | Instruction memory address (low bits of pc) |

## Verification
Reset and a taken branch can land on the same clock edge. The bench provokes this by raising `rst` while it presents a branch whose condition holds and whose offset is nonzero. It then expects the counter to read zero after that edge, not the target.

Outside that case, the bench sweeps every condition code against operand pairs that split equality, signed order and unsigned order from one another. It drives both odd and negative offsets. It steps a model counter arithmetically and compares against it after every edge.

// File: rtl/br_next_pc.sv
module br_next_pc #(
  parameter int XLEN    = 32,
  parameter int IMEM_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               is_branch,
  input  logic [2:0]         funct3,
  input  logic [XLEN-1:0]    rs1_val,
  input  logic [XLEN-1:0]    rs2_val,
  input  logic [XLEN-1:0]    imm,
  output logic [XLEN-1:0]    pc,
  output logic [IMEM_AW-1:0] fetch_addr
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            same, lt_s, lt_u, base_cond, valid_code, taken;
  logic [XLEN-1:0] offset, seq_pc, tgt_pc, nxt_pc;

  assign same   = (rs1_val == rs2_val);
  assign lt_s   = ($signed(rs1_val) < $signed(rs2_val));
  assign lt_u   = (rs1_val < rs2_val);

  always_comb begin
    base_cond  = 1'b0;
    valid_code = 1'b1;
    case (funct3[2:1])
      2'b00:   base_cond = same;
      2'b10:   base_cond = lt_s;
      2'b11:   base_cond = lt_u;
      default: valid_code = 1'b0;
    endcase
  end

  assign taken  = is_branch && valid_code && (base_cond ^ funct3[0]);
  assign offset = {imm[XLEN-1:1], 1'b0};
  assign seq_pc = pc + STEP;
  assign tgt_pc = pc + offset;
  assign nxt_pc = taken ? tgt_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nxt_pc;
  end

  assign fetch_addr = pc[IMEM_AW-1:0];

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == '0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(is_branch)) |-> pc == $past(pc) + STEP);

  // R7
  reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(funct3[2:1]) == 2'b01) |-> pc == $past(pc) + STEP);

  // R6
  even_pc_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> !pc[0]);

  // R3
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(is_branch) && $past(funct3) == 3'b000
     && $past(rs1_val) == $past(rs2_val))
    |-> pc == $past(pc) + {$past(imm[XLEN-1:1]), 1'b0});

endmodule

// File: tb/br_next_pc_tb.sv
module br_next_pc_tb;
  logic        clk = 1'b0;
  logic        rst, is_branch;
  logic [2:0]  funct3;
  logic [31:0] rs1_val, rs2_val, imm;
  logic [31:0] pc;
  logic [15:0] fetch_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  br_next_pc u_dut (
    .clk(clk), .rst(rst), .is_branch(is_branch), .funct3(funct3),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .imm(imm),
    .pc(pc), .fetch_addr(fetch_addr)
  );

  function automatic bit cond_ok(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) <  $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a <  b;
      3'b111: return a >= b;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit br, input logic [2:0] f, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] off, input string req);
    is_branch = br; funct3 = f; rs1_val = a; rs2_val = b; imm = off;
    if (br && cond_ok(f, a, b)) exp_pc = exp_pc + {off[31:1], 1'b0};
    else                        exp_pc = exp_pc + 32'd4;
    @(negedge clk);
    check(req, pc, exp_pc);
    check("R8", {16'h0, fetch_addr}, {16'h0, exp_pc[15:0]});
  endtask

  function automatic string req_of(input logic [2:0] f);
    case (f[2:1])
      2'b00: return "R3";
      2'b01: return "R7";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  logic [31:0] opa [6] = '{32'd5, 32'd3, 32'd7, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000};
  logic [31:0] opb [6] = '{32'd5, 32'd7, 32'd3, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF};

  initial begin
    rst = 1'b1; is_branch = 0; funct3 = 0; rs1_val = 0; rs2_val = 0; imm = 0;
    exp_pc = 0;
    @(negedge clk); @(negedge clk);
    check("R1", pc, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) step(0, 3'b000, 32'd1, 32'd1, 32'd40, "R2");
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 6; p++) begin
        step(1, 3'(f), opa[p], opb[p], 32'd24 + 32'(p), req_of(3'(f)));
        step(1, 3'(f), opa[p], opb[p], -32'd16, req_of(3'(f)));
      end
    step(1, 3'b000, 32'd9, 32'd9, 32'd13, "R6");
    step(1, 3'b001, 32'd9, 32'd8, 32'hFFFF_FFF7, "R6");
    step(0, 3'b000, 32'd9, 32'd9, 32'd100, "R2");
    rst = 1'b1;
    is_branch = 1; funct3 = 3'b000; rs1_val = 1; rs2_val = 1; imm = 32'd64;
    @(negedge clk);
    exp_pc = 0;
    check("R1", pc, 32'd0);
    rst = 1'b0;
    step(1, 3'b000, 32'd1, 32'd1, 32'hFFFF_FFF0, "R6");
    step(0, 3'b000, 32'd0, 32'd0, 32'd0, "R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule